// File: doc/BRIEF.md
# Batched Two-Phase Speculation Validator

This block sits beside a directory's queue of cores that are all waiting on the same contended line. Each queued core beyond the head has run its compare-and-swap sequence speculatively. The value it ran on was the after-value its predecessor announced early. The block checks a whole run of these speculations in one round instead of handing the line down the queue one core at a time.

On `start`, the block latches a snapshot of the queue: a length, a core ID per slot and a stored speculative after-value per slot. Slot 0 is the current owner. It is treated as the non-speculative base that has already passed, and it gets no message.

The block then runs five phases:
- It sends a prepare message to every speculative slot, carrying that slot's stored value.
- It gathers pass or fail replies. A core replies pass only when its swap has completed and its real after-value equals the prepared value. After a pass reply the core freezes.
- It stops gathering when every prepared core has replied, or when a reply window expires. A missing reply counts as fail.
- It decides which slots commit. A slot commits only when it and every slot ahead of it passed.
- It sends one decision per slot: commit, or plain resume. A resumed core is left for serial or later validation.

Top module: `spec_batch_validator`

## Requirements
- R1: A `start` seen while idle with `q_len` in the range 2 to N_SLOTS begins a batch: `busy` is high and the first prepare message is on the outputs one cycle later. A `start` with `q_len` of 0, 1 or above N_SLOTS leaves the block idle and sends nothing.
- R2: Prepare messages go out on consecutive cycles, one per slot 1 to `q_len`-1, in increasing slot order. Each carries that slot's latched core ID and its own latched value. Slot 0 never receives one.
- R3: A reply counts only if all of the following hold: it arrives while prepares are still being sent or during the reply window, it names a slot 1 to `q_len`-1 of the batch, and that slot has already been prepared. The first reply from a slot is the one kept. Replies naming slot 0's core or a core outside the batch have no effect.
- R4: When every prepared slot has replied, the first decision message appears three cycles after the last reply is presented.
- R5: If any prepared slot stays silent, the reply window closes after TIMEOUT cycles and the silent slot is treated as failed. The first decision then appears TIMEOUT+2 cycles after the last prepare message.
- R6: Slot i (i ≥ 1) is committed, `dec_commit`=1, exactly when slots 1..i all replied pass. Once one slot is resumed, every later slot in the batch is resumed too.
- R7: Decision messages go out on consecutive cycles, one per slot 1 to `q_len`-1, in increasing slot order. Each carries that slot's latched core ID. `dec_commit`=0 means resume.
- R8: While a batch runs, changes to `start`, `q_len`, `q_ids` and `q_vals` have no effect on its messages.
- R9: `busy` falls in the cycle after the last decision message. No prepare or decision message is shown while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to validate the presented queue |
| q_len | input | LEN_W | Number of queued slots, head included |
| q_ids | input | N_SLOTS*ID_W | Core ID per slot, slot 0 in the low bits |
| q_vals | input | N_SLOTS*VAL_W | Stored speculative after-value per slot |
| prep_valid | output | 1 | Prepare message present |
| prep_id | output | ID_W | Destination core of the prepare message |
| prep_val | output | VAL_W | After-value the core must match |
| rep_valid | input | 1 | Reply message present |
| rep_id | input | ID_W | Core sending the reply |
| rep_pass | input | 1 | 1 = pass, 0 = fail |
| dec_valid | output | 1 | Decision message present |
| dec_id | output | ID_W | Destination core of the decision |
| dec_commit | output | 1 | 1 = commit, 0 = resume |
| busy | output | 1 | A batch is in progress |

## Verification
The assertions assume that the core IDs in one queue snapshot are distinct. Without that, a reply could match more than one slot. The stimulus builds every snapshot from an odd stride modulo the ID space, so the IDs never repeat. It uses the same stride for the outsider ID it sends as a stray reply. The reply-window bound in the checker also assumes the block never holds more than one batch at a time. The bench respects this: it raises `start` during a batch only to confirm that the request is ignored. It starts a new batch only after it has seen `busy` low.

// File: rtl/spec_batch_validator.sv
module spec_batch_validator #(
  parameter int N_SLOTS = 4,
  parameter int ID_W    = 3,
  parameter int VAL_W   = 16,
  parameter int TIMEOUT = 16,
  localparam int LEN_W  = $clog2(N_SLOTS + 1),
  localparam int IDX_W  = (N_SLOTS > 2) ? $clog2(N_SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LEN_W-1:0]         q_len,
  input  logic [N_SLOTS*ID_W-1:0]  q_ids,
  input  logic [N_SLOTS*VAL_W-1:0] q_vals,
  output logic                     prep_valid,
  output logic [ID_W-1:0]          prep_id,
  output logic [VAL_W-1:0]         prep_val,
  input  logic                     rep_valid,
  input  logic [ID_W-1:0]          rep_id,
  input  logic                     rep_pass,
  output logic                     dec_valid,
  output logic [ID_W-1:0]          dec_id,
  output logic                     dec_commit,
  output logic                     busy
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_COLL, S_DEC, S_REL} st_t;

  st_t                state;
  logic [IDX_W-1:0]   idx, last;
  logic [TMR_W-1:0]   tmr;
  logic [ID_W-1:0]    ids  [N_SLOTS];
  logic [VAL_W-1:0]   vals [N_SLOTS];
  logic [N_SLOTS-1:0] got, pass, cvec;
  logic [N_SLOTS-1:0] got_nx, pass_nx, hit, chain;
  logic               start_ok, all_got;

  assign start_ok = start && (q_len >= LEN_W'(2)) && (q_len <= LEN_W'(N_SLOTS));

  always_comb begin
    for (int s = 0; s < N_SLOTS; s++) begin
      hit[s] = rep_valid && (rep_id == ids[s]) && (s != 0) && (IDX_W'(s) <= last) &&
               ((state == S_COLL) || ((state == S_PREP) && (IDX_W'(s) < idx)));
    end
  end

  always_comb begin
    got_nx  = got;
    pass_nx = pass;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (hit[s] && !got[s]) begin
        got_nx[s]  = 1'b1;
        pass_nx[s] = rep_pass;
      end
    end
  end

  always_comb begin
    all_got = 1'b1;
    for (int s = 0; s < N_SLOTS; s++)
      if (!got[s] && (IDX_W'(s) <= last)) all_got = 1'b0;
  end

  always_comb begin
    chain[0] = pass[0];
    for (int s = 1; s < N_SLOTS; s++) chain[s] = chain[s-1] && pass[s];
  end

  always_ff @(posedge clk) begin
    if ((state == S_IDLE) && start_ok) begin
      for (int s = 0; s < N_SLOTS; s++) begin
        ids[s]  <= q_ids[s*ID_W +: ID_W];
        vals[s] <= q_vals[s*VAL_W +: VAL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      last  <= '0;
      tmr   <= '0;
      got   <= '0;
      pass  <= '0;
      cvec  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_ok) begin
          state <= S_PREP;
          idx   <= IDX_W'(1);
          last  <= IDX_W'(q_len - LEN_W'(1));
          got   <= N_SLOTS'(1);
          pass  <= N_SLOTS'(1);
        end
        S_PREP: begin
          got  <= got_nx;
          pass <= pass_nx;
          tmr  <= '0;
          if (idx == last) state <= S_COLL;
          else             idx   <= idx + IDX_W'(1);
        end
        S_COLL: begin
          got  <= got_nx;
          pass <= pass_nx;
          tmr  <= tmr + TMR_W'(1);
          if (all_got || (tmr == TMR_W'(TIMEOUT - 1))) state <= S_DEC;
        end
        S_DEC: begin
          cvec  <= chain;
          idx   <= IDX_W'(1);
          state <= S_REL;
        end
        S_REL: begin
          if (idx == last) state <= S_IDLE;
          else             idx   <= idx + IDX_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign prep_valid = (state == S_PREP);
  assign prep_id    = ids[idx];
  assign prep_val   = vals[idx];
  assign dec_valid  = (state == S_REL);
  assign dec_id     = ids[idx];
  assign dec_commit = cvec[idx];
endmodule

module spec_batch_validator_chk #(
  parameter int N_SLOTS = 4,
  parameter int TIMEOUT = 16,
  localparam int LEN_W  = $clog2(N_SLOTS + 1),
  localparam int GAP_W  = $clog2(TIMEOUT + 3)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] q_len,
  input logic             prep_valid,
  input logic             dec_valid,
  input logic             dec_commit,
  input logic             busy
);
  logic [GAP_W-1:0] gap;
  logic             quiet, len_ok;

  assign quiet  = busy && !prep_valid && !dec_valid;
  assign len_ok = (q_len >= LEN_W'(2)) && (q_len <= LEN_W'(N_SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gap <= '0;
    else if (quiet) gap <= gap + GAP_W'(1);
    else            gap <= '0;
  end

  // R1
  bad_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !len_ok) |=> !busy);

  // R1
  good_len_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len_ok) |=> (busy && prep_valid));

  // R2
  prep_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prep_valid |-> (busy && !dec_valid));

  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (gap < GAP_W'(TIMEOUT + 1)));

  // R6
  resume_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(dec_valid) && !$past(dec_commit)) |-> !dec_commit);

  // R9
  end_after_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(dec_valid));

  // R9
  dec_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> busy);
endmodule

bind spec_batch_validator spec_batch_validator_chk #(
  .N_SLOTS(N_SLOTS), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .q_len(q_len),
  .prep_valid(prep_valid), .dec_valid(dec_valid), .dec_commit(dec_commit), .busy(busy)
);

// File: tb/sim_spec_batch_validator.sv
`timescale 1ns/1ps
module sim_spec_batch_validator;
  localparam int N  = 4;
  localparam int IW = 3;
  localparam int VW = 8;
  localparam int TO = 8;
  localparam int LW = $clog2(N + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [LW-1:0]   q_len = '0;
  logic [N*IW-1:0] q_ids = '0;
  logic [N*VW-1:0] q_vals = '0;
  logic            prep_valid, dec_valid, dec_commit, busy;
  logic [IW-1:0]   prep_id, dec_id;
  logic [VW-1:0]   prep_val;
  logic            rep_valid = 1'b0;
  logic [IW-1:0]   rep_id = '0;
  logic            rep_pass = 1'b0;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  spec_batch_validator #(.N_SLOTS(N), .ID_W(IW), .VAL_W(VW), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .q_len(q_len), .q_ids(q_ids), .q_vals(q_vals),
    .prep_valid(prep_valid), .prep_id(prep_id), .prep_val(prep_val),
    .rep_valid(rep_valid), .rep_id(rep_id), .rep_pass(rep_pass),
    .dec_valid(dec_valid), .dec_id(dec_id), .dec_commit(dec_commit), .busy(busy));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_batch(int len, int code, int b);
    logic [IW-1:0] id [N];
    logic [VW-1:0] v  [N];
    int rsp [N];
    int cyc, rlast, exp_first, p;
    bit silent, c;
    silent = 0;
    p = 1;
    for (int s = 0; s < N; s++) begin
      id[s]  = IW'((s * 3 + b) % 8);
      v[s]   = VW'((b * 17 + s * 41 + 5) % 256);
      rsp[s] = 0;
      if (s >= 1 && s < len) begin
        rsp[s] = (code / p) % 3;
        p = p * 3;
        if (rsp[s] == 2) silent = 1;
      end
    end
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      q_ids[s*IW +: IW] = id[s];
      q_vals[s*VW +: VW] = v[s];
    end
    q_len = LW'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble the queue inputs while the batch runs
    q_ids  = ~q_ids;
    q_vals = '0;
    q_len  = LW'(1);
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    for (int s = 1; s < len; s++) begin
      if (s > 1) @(negedge clk);
      chk(prep_valid == 1'b1, "R2 prep_valid", int'(prep_valid), 1);
      chk(prep_id == id[s], "R2/R8 prep_id", int'(prep_id), int'(id[s]));
      chk(prep_val == v[s], "R2/R8 prep_val", int'(prep_val), int'(v[s]));
    end
    cyc = 1;
    @(negedge clk);
    chk(prep_valid == 1'b0, "R2 no extra prepare", int'(prep_valid), 0);
    rep_valid = 1'b1; rep_id = IW'((12 + b) % 8); rep_pass = 1'b1;  // R3 outsider
    start = 1'b1;                                                    // R8 start while busy
    @(negedge clk); cyc++;
    rep_id = id[0]; rep_pass = 1'b1;                                 // R3 head reply
    start = 1'b0;
    for (int s = len - 1; s >= 1; s--) begin
      if (rsp[s] != 2) begin
        @(negedge clk); cyc++;
        rep_id = id[s];
        rep_pass = (rsp[s] == 0);
      end
    end
    @(negedge clk); cyc++;
    rep_valid = 1'b0;
    rlast = cyc - 1;
    exp_first = silent ? (TO + 2) : (rlast + 3);
    while (!dec_valid && cyc < 40) begin
      @(negedge clk); cyc++;
    end
    if (silent) chk(cyc == exp_first, "R5 timeout decision cycle", cyc, exp_first);
    else        chk(cyc == exp_first, "R4 all-replied decision cycle", cyc, exp_first);
    c = 1;
    for (int s = 1; s < len; s++) begin
      if (s > 1) @(negedge clk);
      c = c && (rsp[s] == 0);
      chk(dec_valid == 1'b1, "R7 dec_valid", int'(dec_valid), 1);
      chk(dec_id == id[s], "R7/R8 dec_id", int'(dec_id), int'(id[s]));
      chk(dec_commit == c, "R6/R3 dec_commit", int'(dec_commit), int'(c));
    end
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy falls", int'(busy), 0);
    chk(dec_valid == 1'b0, "R9 no decision when idle", int'(dec_valid), 0);
  endtask

  initial begin
    int lens [3];
    int b;
    lens = '{0, 1, 5};
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(prep_valid == 1'b0, "R9 reset prep_valid", int'(prep_valid), 0);
    chk(dec_valid == 1'b0, "R9 reset dec_valid", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      q_len = LW'(lens[k]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b0, "R1 bad length ignored", int'(busy), 0);
      chk(prep_valid == 1'b0, "R1 no prepare for bad length", int'(prep_valid), 0);
      @(negedge clk);
    end
    b = 0;
    for (int len = 2; len <= N; len++) begin
      int combos = 1;
      for (int s = 1; s < len; s++) combos = combos * 3;
      for (int code = 0; code < combos; code++) begin
        run_batch(len, code, b);
        b++;
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule